// File: doc/BRIEF.md
# Subword Shift and Permute Unit

This unit works on a word of `W` bits (64 by default), viewed as a row of equal subwords of 8, 16, 32 or 64 bits. It handles the shift-and-rearrange class of packed-media operations. The operations are per-subword shifts left, logical right and arithmetic right by one common amount. It also does a funnel shift that joins two sources and keeps the low half, which becomes a rotate when both sources carry the same value. Two interleave operations merge alternate subwords of two sources, which is the building step for transposing small matrices held in packed registers. A last operation rebuilds a word from its own bytes or half-words under control of a selector.

The shift amount comes from one of two places. It can be an immediate input, or the low byte of the second source, which gives the variable form. The caller supplies the opcode and the size code already decoded. The unit computes every candidate result in parallel, selects one, and holds it in a single output register. A result therefore appears one clock after its operands.

Top module: `subword_shuffle_unit`

## Requirements
- R1: While reset is asserted and at the first sample after its release, `result_o` is all zeros.
- R2: `result_o` is registered. Operands presented before a rising clock edge appear at `result_o` after that edge and not before it.
- R3: Opcode 0 shifts every subword left by `imm_i`, filling with zeros. The size code selects the subword width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. An amount equal to or above the subword width yields a zero subword.
- R4: Opcode 1 shifts every subword right by `imm_i`, filling with zeros. An amount equal to or above the subword width yields zero.
- R5: Opcode 2 shifts every subword right by `imm_i` and fills with copies of that subword's top bit. An amount equal to or above the subword width gives all copies of the top bit.
- R6: Opcodes 4, 5 and 6 behave like opcodes 0, 1 and 2 respectively. Their amount is `src_b_i[7:0]`, read as unsigned, in place of `imm_i`. Opcode bit 2 selects the register source.
- R7: Opcode 8 forms the 2W-bit value {`src_a_i`, `src_b_i`} with A in the upper half. It shifts that value right by `imm_i` and returns the low W bits. The size code is ignored.
- R8: With opcode 8 and equal sources, the result is `src_a_i` rotated right by `imm_i`.
- R9: Opcode 9 (interleave even) works on each pair of subwords 2j and 2j+1. Result subword 2j is B's subword 2j, and result subword 2j+1 is A's subword 2j. Subword 0 is the least significant.
- R10: Opcode 10 (interleave odd) works on the same pairs. Result subword 2j is B's subword 2j+1, and result subword 2j+1 is A's subword 2j+1.
- R11: Opcode 11 rearranges subwords of A. With size code 0, result byte k is A's byte `psel_i[3k+2:3k]`. With size code 1, result half-word k is A's half-word `psel_i[2k+1:2k]`.
- R12: The result is all zeros in three cases: opcodes 3, 7 and 12 to 15; opcodes 9 and 10 with size code 3; and opcode 11 with size code 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Subword size code |
| src_a_i | input | W | First source word |
| src_b_i | input | W | Second source word; low byte is the variable shift amount |
| imm_i | input | log2(W) | Immediate shift amount |
| psel_i | input | (W/8)*log2(W/8) | Packed subword index fields for the rearrange operation |
| result_o | output | W | Registered result |

## Verification
Two situations can occur together in one cycle. An oversized variable shift amount can meet the arithmetic sign fill. A funnel shift can also become a rotation. The first case is provoked by sweeping the low byte of B beyond each subword width while A carries negative lanes. The second is provoked by driving equal sources through every funnel amount. Both outcomes are judged against an arithmetic model in the bench, which builds each lane from masks and shifts of whole words. A popcount property also checks every rotation.

// File: rtl/subword_shuffle_unit.sv
module subword_shuffle_unit #(
  parameter int W = 64,
  parameter int AMTW = 8,
  localparam int LW = $clog2(W),
  localparam int SELW = (W / 8) * $clog2(W / 8)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_i,
  input  logic [1:0]      size_i,
  input  logic [W-1:0]    src_a_i,
  input  logic [W-1:0]    src_b_i,
  input  logic [LW-1:0]   imm_i,
  input  logic [SELW-1:0] psel_i,
  output logic [W-1:0]    result_o
);
  localparam int NSZ = 4;
  localparam int NB = W / 8;
  localparam int BIW = $clog2(NB);
  localparam int NH = W / 16;
  localparam int HIW = $clog2(NH);

  logic [AMTW-1:0] amt;
  logic arith;
  logic [NSZ-1:0][W-1:0] shl_r, shr_r, mixe_r, mixo_r;
  logic [W-1:0] perm_b, perm_h, fun_r, nxt;
  logic [2*W-1:0] cat;

  assign amt = op_i[2] ? src_b_i[AMTW-1:0] : AMTW'(imm_i);
  assign arith = (op_i[1:0] == 2'd2);

  genvar s, i;
  generate
    for (s = 0; s < NSZ; s++) begin : g_sz
      localparam int SW = 8 << s;
      localparam int N = W / SW;
      for (i = 0; i < N; i++) begin : g_lane
        logic [SW-1:0] lane;
        logic big;
        assign lane = src_a_i[i*SW +: SW];
        assign big = amt >= AMTW'(SW);
        assign shl_r[s][i*SW +: SW] = big ? '0 : lane << amt;
        assign shr_r[s][i*SW +: SW] = big ? {SW{arith & lane[SW-1]}} :
                                      arith ? $unsigned($signed(lane) >>> amt) : lane >> amt;
      end
      if (N >= 2) begin : g_mix
        for (i = 0; i < N / 2; i++) begin : g_pair
          assign mixe_r[s][2*i*SW +: SW]     = src_b_i[2*i*SW +: SW];
          assign mixe_r[s][(2*i+1)*SW +: SW] = src_a_i[2*i*SW +: SW];
          assign mixo_r[s][2*i*SW +: SW]     = src_b_i[(2*i+1)*SW +: SW];
          assign mixo_r[s][(2*i+1)*SW +: SW] = src_a_i[(2*i+1)*SW +: SW];
        end
      end else begin : g_nomix
        assign mixe_r[s] = '0;
        assign mixo_r[s] = '0;
      end
    end

    for (i = 0; i < NB; i++) begin : g_pb
      logic [BIW-1:0] idx;
      assign idx = psel_i[i*BIW +: BIW];
      assign perm_b[i*8 +: 8] = src_a_i[{idx, 3'b000} +: 8];
    end
    for (i = 0; i < NH; i++) begin : g_ph
      logic [HIW-1:0] idx;
      assign idx = psel_i[i*HIW +: HIW];
      assign perm_h[i*16 +: 16] = src_a_i[{idx, 4'b0000} +: 16];
    end
  endgenerate

  assign cat = {src_a_i, src_b_i} >> imm_i;
  assign fun_r = cat[W-1:0];

  always_comb begin
    case (op_i)
      4'h0, 4'h4:             nxt = shl_r[size_i];
      4'h1, 4'h2, 4'h5, 4'h6: nxt = shr_r[size_i];
      4'h8:                   nxt = fun_r;
      4'h9:                   nxt = mixe_r[size_i];
      4'hA:                   nxt = mixo_r[size_i];
      4'hB:                   nxt = (size_i == 2'd0) ? perm_b : (size_i == 2'd1) ? perm_h : '0;
      default:                nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) result_o <= '0;
    else        result_o <= nxt;
endmodule

// File: rtl/subword_shuffle_unit_chk.sv
module subword_shuffle_unit_chk #(
  parameter int W = 64,
  parameter int AMTW = 8,
  localparam int LW = $clog2(W),
  localparam int SELW = (W / 8) * $clog2(W / 8)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      op_i,
  input logic [1:0]      size_i,
  input logic [W-1:0]    src_a_i,
  input logic [W-1:0]    src_b_i,
  input logic [LW-1:0]   imm_i,
  input logic [SELW-1:0] psel_i,
  input logic [W-1:0]    result_o
);
  AST_SHL_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'h0 && size_i == 2'd0 && imm_i != '0) |=> ((result_o & {(W/8){8'h01}}) == '0)); // R3
  AST_WIDE_LSR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'h5 && src_b_i[AMTW-1:0] >= AMTW'(W)) |=> (result_o == '0)); // R4
  AST_SRA_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'h2 && size_i == 2'd3) |=> (result_o[W-1] == $past(src_a_i[W-1]))); // R5
  AST_ROT_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'h8 && src_a_i == src_b_i) |=> ($countones(result_o) == $countones($past(src_a_i)))); // R8
  AST_MIX_SELF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'h9 && size_i == 2'd0 && src_a_i == src_b_i) |=>
    ((result_o & {(W/16){16'h00FF}}) == ((result_o >> 8) & {(W/16){16'h00FF}}))); // R9
  AST_PERM_BYTE0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'hB && size_i == 2'd0 && psel_i == '0) |=> (result_o == {(W/8){$past(src_a_i[7:0])}})); // R11
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'h3 || op_i == 4'h7 || op_i >= 4'hC) |=> (result_o == '0)); // R12
endmodule

bind subword_shuffle_unit subword_shuffle_unit_chk #(.W(W), .AMTW(AMTW)) u_chk (.*);

// File: tb/subword_shuffle_unit_tb.sv
`timescale 1ns/1ps
module subword_shuffle_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [1:0] size_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic [5:0] imm_i = '0;
  logic [23:0] psel_i = '0;
  logic [63:0] result_o;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [63:0] lcg = 64'h0123_4567_89AB_CDEF;

  always #2.5 clk = ~clk;

  subword_shuffle_unit u_dut (.clk, .rst_n, .op_i, .size_i, .src_a_i, .src_b_i,
                              .imm_i, .psel_i, .result_o);

  function automatic logic [63:0] rnd();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg;
  endfunction

  function automatic logic [63:0] model(logic [3:0] op, logic [1:0] sz, logic [63:0] a, logic [63:0] b,
                                        logic [5:0] imm, logic [23:0] sel);
    int sw, n, amt, off;
    logic [63:0] r, m, v, lo, hi;
    logic [127:0] cat;
    bit neg;
    sw = 8 << sz; n = 64 / sw; r = '0;
    m = (sw == 64) ? '1 : (64'd1 << sw) - 64'd1;
    amt = op[2] ? int'(b[7:0]) : int'(imm);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6:
        for (int k = 0; k < n; k++) begin
          v = (a >> (k * sw)) & m;
          if (op[1:0] == 2'd0) v = (amt >= sw) ? '0 : (v << amt) & m;
          else begin
            neg = (op[1:0] == 2'd2) && v[sw-1];
            v = (amt >= sw) ? '0 : v >> amt;
            if (neg) v = v | (m & ~(m >> ((amt >= sw) ? sw : amt)));
          end
          r = r | (v << (k * sw));
        end
      4'd8: begin cat = {a, b} >> imm; r = cat[63:0]; end
      4'd9, 4'd10:
        if (sz != 2'd3) begin
          off = (op == 4'd10) ? 1 : 0;
          for (int j = 0; j < n / 2; j++) begin
            lo = (b >> ((2 * j + off) * sw)) & m;
            hi = (a >> ((2 * j + off) * sw)) & m;
            r = r | (lo << (2 * j * sw)) | (hi << ((2 * j + 1) * sw));
          end
        end
      4'd11:
        if (sz == 2'd0) begin
          for (int k = 0; k < 8; k++) r = r | (((a >> (8 * int'(sel[3*k +: 3]))) & 64'hFF) << (8 * k));
        end else if (sz == 2'd1) begin
          for (int k = 0; k < 4; k++) r = r | (((a >> (16 * int'(sel[2*k +: 2]))) & 64'hFFFF) << (16 * k));
        end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] op, logic [1:0] sz, logic [63:0] a, logic [63:0] b);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd8: return (a == b) ? "R8" : "R7";
      4'd9: return (sz == 2'd3) ? "R12" : "R9";
      4'd10: return (sz == 2'd3) ? "R12" : "R10";
      4'd11: return (sz[1]) ? "R12" : "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s op=%0h size=%0d actual=%h expected=%h", tag, op_i, size_i, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b,
                     input logic [5:0] imm, input logic [23:0] sel);
    logic [63:0] exp;
    exp = model(op, sz, a, b, imm, sel);
    op_i = op; size_i = sz; src_a_i = a; src_b_i = b; imm_i = imm; psel_i = sel;
    @(negedge clk);
    check(tag_of(op, sz, a, b), result_o, exp);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    logic [63:0] pats [4];
    logic [63:0] prev;
    pats[0] = 64'h8000_7F01_FF80_0102;
    pats[1] = 64'hF0E1_D2C3_B4A5_9687;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1", result_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", result_o, 64'd0);

    // R2: not visible before the edge, visible after it
    op_i = 4'h8; size_i = 2'd0; src_a_i = pats[2]; src_b_i = pats[1]; imm_i = 6'd4; psel_i = '0;
    #1 check("R2", result_o, 64'd0);
    @(negedge clk);
    check("R2", result_o, model(4'h8, 2'd0, pats[2], pats[1], 6'd4, 24'd0));

    // R3 R4 R5: immediate shifts
    for (int op = 0; op < 3; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int am = 0; am < 64; am++)
          for (int p = 0; p < 4; p++)
            run(4'(op), 2'(sz), pats[p] ^ rnd() & {64{p == 3}}, rnd(), 6'(am), 24'd0);

    // R6: register-sourced amount, including values past every width
    for (int op = 4; op < 7; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int am = 0; am < 80; am++)
          for (int p = 0; p < 4; p++)
            run(4'(op), 2'(sz), pats[p], {rnd() & 64'hFFFF_FFFF_FFFF_FF00} | 64'(am), 6'd0, 24'd0);
    for (int op = 4; op < 7; op++)
      for (int sz = 0; sz < 4; sz++)
        run(4'(op), 2'(sz), pats[0], 64'h0000_0000_0000_00FF, 6'd1, 24'd0);

    // R7 R8: funnel and rotate
    for (int am = 0; am < 64; am++)
      for (int p = 0; p < 4; p++) begin
        run(4'h8, 2'(p), pats[p], pats[(p + 1) % 4], 6'(am), 24'd0);
        prev = rnd();
        run(4'h8, 2'(3 - p), prev, prev, 6'(am), 24'd0);
      end

    // R9 R10 R12: interleaves across sizes
    for (int op = 9; op < 11; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int p = 0; p < 8; p++) begin
          prev = rnd();
          run(4'(op), 2'(sz), prev, (p == 0) ? prev : rnd(), 6'd0, 24'd0);
        end

    // R11 R12: rearrangement
    for (int sz = 0; sz < 4; sz++)
      for (int p = 0; p < 100; p++)
        run(4'hB, 2'(sz), rnd(), rnd(), 6'd0, (p == 0) ? 24'd0 : 24'(rnd()));
    run(4'hB, 2'd0, pats[2], 64'd0, 6'd0, 24'b000_001_010_011_100_101_110_111);

    // R12: unassigned codes
    for (int op = 0; op < 16; op++)
      if (op == 3 || op == 7 || op >= 12)
        for (int sz = 0; sz < 4; sz++)
          run(4'(op), 2'(sz), pats[sz], pats[3 - sz], 6'd5, 24'hFFFFFF);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule